// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block turns one fast source clock into three banks of divided clock outputs plus a feedback output. The source is either the oscillator clock or, in bypass, one of two reference clocks. The chosen source first goes through a pre-divider that divides by 2 or by 4. Each bank and the feedback path then divide that pre-divided rate by their own selectable ratio. The outputs therefore keep fixed integer frequency relationships, such as 3:2 or 3:1, and they share a common rising edge.

A small control state machine has three states. HALT is held while the active-low master reset is low, and the output-enable flags are low in it. HALT goes to START on the first source edge after reset is released. In that edge the select inputs are captured and every counter is loaded. START goes to RUN on the next edge, and RUN holds until the next reset. Select inputs that change during RUN are taken up only at the common alignment point, which comes once every 24 pre-divided periods. The clock enable passes through a two-flop synchronizer. It can gate each bank only while that bank's output is low. The feedback output is never gated.

Top module: `mbank_clkdiv`

## Requirements
- R1: While rst_n is low, all of qa, qb, qc and qfb are 0 and oe_bank and oe_fb are 0, asynchronously. Both flags become 1 on the first source rising edge after rst_n goes high. State changes from START to RUN on the next edge after that.
- R2: The source clock is clk_vco when pll_mode is 1. When pll_mode is 0 (bypass), the source is clk_ref0 if ref_sel is 0 and clk_ref1 if ref_sel is 1.
- R3: The pre-divider ratio P is 2 when pre_sel is 0 and 4 when pre_sel is 1. Two pre-divided ticks are never one source cycle apart.
- R4: Banks A (qa) and B (qb) divide the pre-divided rate by 2 when sel_a or sel_b is 0, and by 4 when it is 1. The output period is N*P source cycles. All bits of a bank carry the same value.
- R5: Bank C (qc) divides the pre-divided rate by 4 when sel_c is 0 and by 6 when it is 1.
- R6: The feedback output qfb divides the pre-divided rate by 4, 6, 8 or 12 for fb_sel codes 00, 01, 10 and 11.
- R7: Every output has a 50% duty cycle, high for N*P/2 source cycles. All outputs rise together on source edge 1+P after reset release, counting the first edge as 1, and they are low before that edge.
- R8: When clk_en is low, qa, qb and qc settle to 0 and qfb keeps toggling. When clk_en is high, the bank outputs follow their dividers.
- R9: Changes of clk_en take effect on a bank only while that bank's output is low. Every high pulse of a bank output lasts exactly N*P/2 source cycles, even across enable changes.
- R10: The bank and feedback ratios are taken from the select inputs at each alignment point. Alignment points come every 24 pre-divided ticks, starting with the first common rising edge. Between alignment points the ratios in use do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast oscillator clock, the source when pll_mode is 1 |
| clk_ref0 | input | 1 | Reference clock 0, the bypass source when ref_sel is 0 |
| clk_ref1 | input | 1 | Reference clock 1, the bypass source when ref_sel is 1 |
| ref_sel | input | 1 | Picks the reference clock used in bypass |
| pll_mode | input | 1 | 1 selects clk_vco, 0 selects the chosen reference clock |
| pre_sel | input | 1 | Pre-divider: 0 divides by 2, 1 divides by 4 |
| sel_a | input | 1 | Bank A ratio: 0 is ÷2, 1 is ÷4 |
| sel_b | input | 1 | Bank B ratio: 0 is ÷2, 1 is ÷4 |
| sel_c | input | 1 | Bank C ratio: 0 is ÷4, 1 is ÷6 |
| fb_sel | input | 2 | Feedback ratio code: 00 ÷4, 01 ÷6, 10 ÷8, 11 ÷12 |
| rst_n | input | 1 | Active-low master reset; disables outputs and clears counters |
| clk_en | input | 1 | Bank clock enable; low holds the bank outputs low |
| qa | output | NA | Bank A divided clock outputs |
| qb | output | NB | Bank B divided clock outputs |
| qc | output | NC | Bank C divided clock outputs |
| qfb | output | 1 | Feedback divided clock output, never gated |
| oe_bank | output | 1 | Output-enable flag for the bank pad drivers (0 means high impedance) |
| oe_fb | output | 1 | Output-enable flag for the feedback pad driver |

## Verification
The bench aims at the first common rising edge after reset and at full-width high pulses. If the START load or the pre-divider phase were off, the outputs would rise a cycle early or late, or the banks would drift apart. It drops clk_en just as a bank pulse rises and raises it again later. A design that gates without waiting for the low phase would emit a shortened pulse, and one that gates the feedback output would stop qfb. It changes the ratio selects between alignment points. A design that applies them at once would change frequency before the next 24-tick boundary and lose phase alignment. Bypass runs are sampled on the reference clocks, so a source mux that ignores pll_mode or ref_sel shows a period mismatch.

// File: rtl/mbcd_pkg.sv
package mbcd_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2
    } ctrl_state_t;

    function automatic int pick2(input logic sel, input int r0, input int r1);
        return sel ? r1 : r0;
    endfunction

    function automatic int pick4(input logic [1:0] code, input int r0, input int r1,
                                 input int r2, input int r3);
        int r;
        case (code)
            2'b00:   r = r0;
            2'b01:   r = r1;
            2'b10:   r = r2;
            default: r = r3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mbcd_ctrl.sv
module mbcd_ctrl
    import mbcd_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic en_async,
    output logic load,
    output logic oe,
    output logic en_s
);

    ctrl_state_t state_q, state_nx;
    logic        en_m;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_HALT;
        else         state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_HALT:  state_nx = ST_START;
            ST_START: state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_HALT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_HALT:  begin load = 1'b1; oe = 1'b0; end
            ST_START: begin load = 1'b0; oe = 1'b1; end
            ST_RUN:   begin load = 1'b0; oe = 1'b1; end
            default:  begin load = 1'b1; oe = 1'b0; end
        endcase
    end

    // two-flop synchronizer for the enable
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            en_m <= 1'b0;
            en_s <= 1'b0;
        end else begin
            en_m <= en_async;
            en_s <= en_m;
        end
    end

    // R1: START lasts exactly one edge
    p_start_to_run_r1: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_START) |=> (state_q == ST_RUN));

endmodule

// File: rtl/mbcd_prediv.sv
module mbcd_prediv #(
    parameter int RW        = 4,
    parameter int PHASE_LEN = 24,
    parameter int RST_RATIO = 2,
    localparam int PW       = $clog2(PHASE_LEN)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          load,
    input  logic [RW-1:0] pre_in,
    output logic          tick,
    output logic          align
);

    logic [RW-1:0] pc;
    logic [RW-1:0] pratio;
    logic [PW-1:0] ph;

    assign tick  = !load && (pc == pratio - RW'(1));
    assign align = (ph == PW'(PHASE_LEN - 1));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pc     <= '0;
            pratio <= RW'(RST_RATIO);
            ph     <= PW'(PHASE_LEN - 1);
        end else if (load) begin
            pc     <= '0;
            pratio <= pre_in;
            ph     <= PW'(PHASE_LEN - 1);
        end else if (tick) begin
            pc <= '0;
            if (align) begin
                ph     <= '0;
                pratio <= pre_in;
            end else begin
                ph <= ph + PW'(1);
            end
        end else begin
            pc <= pc + RW'(1);
        end
    end

    // R3: ticks are at least two source cycles apart
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!arst_n)
        tick |=> !tick);

endmodule

// File: rtl/mbcd_ratio_div.sv
module mbcd_ratio_div #(
    parameter int RW        = 4,
    parameter int RST_RATIO = 2
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          load,
    input  logic          tick,
    input  logic          align,
    input  logic [RW-1:0] ratio_in,
    output logic          q
);

    logic [RW-1:0] ratio;
    logic [RW-1:0] cnt;
    logic [RW-1:0] cnt_nx;

    always_comb begin
        if (cnt == ratio - RW'(1)) cnt_nx = '0;
        else                       cnt_nx = cnt + RW'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ratio <= RW'(RST_RATIO);
            cnt   <= '0;
            q     <= 1'b0;
        end else if (load) begin
            ratio <= ratio_in;
            cnt   <= ratio_in - RW'(1);
            q     <= 1'b0;
        end else if (tick) begin
            if (align) begin
                ratio <= ratio_in;
                cnt   <= '0;
                q     <= 1'b1;
            end else begin
                cnt <= cnt_nx;
                q   <= (cnt_nx < (ratio >> 1));
            end
        end
    end

    // R7: an output only rises on a pre-divided tick
    p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(q) |-> $past(tick));

    // R4: phase counter stays inside the active ratio
    p_cnt_below_ratio_r4: assert property (@(posedge clk) disable iff (!arst_n)
        !load |-> (cnt < ratio));

endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv
    import mbcd_pkg::*;
#(
    parameter int NA        = 5,
    parameter int NB        = 5,
    parameter int NC        = 4,
    parameter int RW        = 4,
    parameter int PHASE_LEN = 24,
    parameter int PRE0      = 2,
    parameter int PRE1      = 4,
    parameter int RA0       = 2,
    parameter int RA1       = 4,
    parameter int RB0       = 2,
    parameter int RB1       = 4,
    parameter int RC0       = 4,
    parameter int RC1       = 6,
    parameter int RF0       = 4,
    parameter int RF1       = 6,
    parameter int RF2       = 8,
    parameter int RF3       = 12,
    localparam int NBANK    = 3
) (
    input  logic          clk_vco,
    input  logic          clk_ref0,
    input  logic          clk_ref1,
    input  logic          ref_sel,
    input  logic          pll_mode,
    input  logic          pre_sel,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic [1:0]    fb_sel,
    input  logic          rst_n,
    input  logic          clk_en,
    output logic [NA-1:0] qa,
    output logic [NB-1:0] qb,
    output logic [NC-1:0] qc,
    output logic          qfb,
    output logic          oe_bank,
    output logic          oe_fb
);

    logic              src_clk;
    logic              load, oe, en_s;
    logic              tick, align;
    logic [RW-1:0]     pre_ratio;
    logic [RW-1:0]     bank_ratio [NBANK];
    logic [RW-1:0]     fb_ratio;
    logic [NBANK-1:0]  bank_q;
    logic [NBANK-1:0]  gate;
    logic              fb_q;

    assign src_clk = pll_mode ? clk_vco : (ref_sel ? clk_ref1 : clk_ref0);

    assign pre_ratio     = RW'(pick2(pre_sel, PRE0, PRE1));
    assign bank_ratio[0] = RW'(pick2(sel_a, RA0, RA1));
    assign bank_ratio[1] = RW'(pick2(sel_b, RB0, RB1));
    assign bank_ratio[2] = RW'(pick2(sel_c, RC0, RC1));
    assign fb_ratio      = RW'(pick4(fb_sel, RF0, RF1, RF2, RF3));

    mbcd_ctrl u_ctrl (
        .clk      (src_clk),
        .arst_n   (rst_n),
        .en_async (clk_en),
        .load     (load),
        .oe       (oe),
        .en_s     (en_s)
    );

    mbcd_prediv #(.RW(RW), .PHASE_LEN(PHASE_LEN), .RST_RATIO(PRE0)) u_prediv (
        .clk    (src_clk),
        .arst_n (rst_n),
        .load   (load),
        .pre_in (pre_ratio),
        .tick   (tick),
        .align  (align)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        mbcd_ratio_div #(.RW(RW), .RST_RATIO(RA0)) u_div (
            .clk      (src_clk),
            .arst_n   (rst_n),
            .load     (load),
            .tick     (tick),
            .align    (align),
            .ratio_in (bank_ratio[b]),
            .q        (bank_q[b])
        );

        // enable may only move while this bank is low
        always_ff @(posedge src_clk or negedge rst_n) begin
            if (!rst_n)         gate[b] <= 1'b0;
            else if (!bank_q[b]) gate[b] <= en_s;
        end

        // R9: gate changes only follow a low bank phase
        p_gate_when_low_r9: assert property (@(posedge src_clk) disable iff (!rst_n)
            !$stable(gate[b]) |-> !$past(bank_q[b]));
    end

    mbcd_ratio_div #(.RW(RW), .RST_RATIO(RF0)) u_fbdiv (
        .clk      (src_clk),
        .arst_n   (rst_n),
        .load     (load),
        .tick     (tick),
        .align    (align),
        .ratio_in (fb_ratio),
        .q        (fb_q)
    );

    assign qa      = {NA{bank_q[0] & gate[0]}};
    assign qb      = {NB{bank_q[1] & gate[1]}};
    assign qc      = {NC{bank_q[2] & gate[2]}};
    assign qfb     = fb_q;
    assign oe_bank = oe;
    assign oe_fb   = oe;

endmodule

// File: tb/mbank_clkdiv_tb_top.sv
module mbank_clkdiv_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int REF0_PER   = 14;
    localparam int REF1_PER   = 18;
    localparam int NA = 5;
    localparam int NB = 5;
    localparam int NC = 4;

    logic clk_vco = 0, clk_ref0 = 0, clk_ref1 = 0;
    logic ref_sel = 0, pll_mode = 1, pre_sel = 0;
    logic sel_a = 0, sel_b = 0, sel_c = 0;
    logic [1:0] fb_sel = 0;
    logic rst_n = 0, clk_en = 1;
    logic [NA-1:0] qa;
    logic [NB-1:0] qb;
    logic [NC-1:0] qc;
    logic qfb, oe_bank, oe_fb;

    always #(CLK_PERIOD/2) clk_vco  = ~clk_vco;
    always #(REF0_PER/2)   clk_ref0 = ~clk_ref0;
    always #(REF1_PER/2)   clk_ref1 = ~clk_ref1;

    mbank_clkdiv dut_i (
        .clk_vco(clk_vco), .clk_ref0(clk_ref0), .clk_ref1(clk_ref1),
        .ref_sel(ref_sel), .pll_mode(pll_mode), .pre_sel(pre_sel),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .fb_sel(fb_sel),
        .rst_n(rst_n), .clk_en(clk_en),
        .qa(qa), .qb(qb), .qc(qc), .qfb(qfb),
        .oe_bank(oe_bank), .oe_fb(oe_fb)
    );

    int total = 0;
    int bad   = 0;
    int src_which = 0;
    int s = 0;
    int p = 2;
    int n0 [3];
    int n1 [3];
    int nf = 4;
    int chg = 1 << 30;
    int run [3];

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        total++;
        if (!c) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_src();
        case (src_which)
            0: @(negedge clk_vco);
            1: @(negedge clk_ref0);
            default: @(negedge clk_ref1);
        endcase
    endtask

    function automatic bit mdl(input int si, input int na, input int nb);
        int t, seg_s, n;
        if (si < 1 + p) return 1'b0;
        t = (si - 1 - p) / p;
        seg_s = 1 + p + (t / 24) * 24 * p;
        n = (seg_s > chg) ? nb : na;
        return (t % n) < (n / 2);
    endfunction

    task automatic start(input int which, input bit pm, input bit rs, input bit ps,
                         input bit sa, input bit sb, input bit sc,
                         input logic [1:0] fs, input bit en);
        rst_n = 0;
        #1;
        pll_mode = pm; ref_sel = rs; pre_sel = ps;
        sel_a = sa; sel_b = sb; sel_c = sc; fb_sel = fs; clk_en = en;
        src_which = which;
        p = ps ? 4 : 2;
        n0[0] = sa ? 4 : 2;
        n0[1] = sb ? 4 : 2;
        n0[2] = sc ? 6 : 4;
        for (int b = 0; b < 3; b++) begin n1[b] = n0[b]; run[b] = 0; end
        case (fs)
            2'b00: nf = 4;
            2'b01: nf = 6;
            2'b10: nf = 8;
            default: nf = 12;
        endcase
        chg = 1 << 30;
        repeat (4) wait_src();
        chk(qa == 0 && qb == 0 && qc == 0 && qfb == 0, "R1 outputs low in reset",
            int'({qa[0], qb[0], qc[0], qfb}), 0);
        chk(!oe_bank && !oe_fb, "R1 enable flags low in reset", int'({oe_bank, oe_fb}), 0);
        rst_n = 1;
        s = 0;
    endtask

    // gmode 0: exact, 1: enable transition, 2: banks held low
    task automatic check_win(input int n, input int gmode, input string tag);
        int  bad_b [3];
        int  first_act [3];
        int  first_exp [3];
        int  bad_f, bad_oe, f_act, f_exp;
        bit  ob [3];
        bit  eb [3];
        bit  uni [3];
        bit  ef;
        bad_f = 0; bad_oe = 0; f_act = 0; f_exp = 0;
        for (int b = 0; b < 3; b++) begin bad_b[b] = 0; first_act[b] = 0; first_exp[b] = 0; end
        for (int i = 0; i < n; i++) begin
            wait_src();
            s++;
            ob[0] = qa[0]; uni[0] = (qa == {NA{qa[0]}});
            ob[1] = qb[0]; uni[1] = (qb == {NB{qb[0]}});
            ob[2] = qc[0]; uni[2] = (qc == {NC{qc[0]}});
            for (int b = 0; b < 3; b++) begin
                bit wrong;
                eb[b] = mdl(s, n0[b], n1[b]);
                wrong = !uni[b];
                case (gmode)
                    0: if (ob[b] != eb[b]) wrong = 1;
                    1: if (ob[b] && !eb[b]) wrong = 1;
                    default: if (ob[b]) wrong = 1;
                endcase
                if (wrong) begin
                    if (bad_b[b] == 0) begin first_act[b] = int'(ob[b]); first_exp[b] = int'(eb[b]); end
                    bad_b[b]++;
                end
                if (ob[b]) run[b]++;
                else begin
                    if (run[b] > 0 && gmode == 1)
                        chk(run[b] == n0[b] * p / 2, {tag, " R9 full-width bank pulse"},
                            run[b], n0[b] * p / 2);
                    run[b] = 0;
                end
            end
            ef = mdl(s, nf, nf);
            if (qfb != ef) begin
                if (bad_f == 0) begin f_act = int'(qfb); f_exp = int'(ef); end
                bad_f++;
            end
            if (!(oe_bank && oe_fb)) bad_oe++;
        end
        if (bad_b[0] != 0) $display("  bank A first mismatch actual=%0d expected=%0d", first_act[0], first_exp[0]);
        if (bad_b[1] != 0) $display("  bank B first mismatch actual=%0d expected=%0d", first_act[1], first_exp[1]);
        if (bad_b[2] != 0) $display("  bank C first mismatch actual=%0d expected=%0d", first_act[2], first_exp[2]);
        if (bad_f != 0)    $display("  feedback first mismatch actual=%0d expected=%0d", f_act, f_exp);
        chk(bad_b[0] == 0, {tag, " bank A mismatches"}, bad_b[0], 0);
        chk(bad_b[1] == 0, {tag, " bank B mismatches"}, bad_b[1], 0);
        chk(bad_b[2] == 0, {tag, " bank C mismatches"}, bad_b[2], 0);
        chk(bad_f == 0, {tag, " feedback mismatches"}, bad_f, 0);
        chk(bad_oe == 0, {tag, " R1 enable flags high"}, bad_oe, 0);
    endtask

    task automatic t_reset_async();
        start(0, 1, 0, 0, 0, 0, 0, 2'b00, 1);
        check_win(40, 0, "R1 run before reset");
        #(CLK_PERIOD/4);
        rst_n = 0;
        #1;
        chk(qa == 0 && qb == 0 && qc == 0 && qfb == 0, "R1 async clear of outputs",
            int'({qa[0], qb[0], qc[0], qfb}), 0);
        chk(!oe_bank && !oe_fb, "R1 async clear of enable flags", int'({oe_bank, oe_fb}), 0);
    endtask

    task automatic t_ratios(input bit ps, input bit sa, input bit sb, input bit sc,
                            input logic [1:0] fs, input string tag);
        start(0, 1, 0, ps, sa, sb, sc, fs, 1);
        check_win(p, 0, {tag, " R7 before first edge"});
        chk(qa == 0 && qb == 0 && qc == 0 && qfb == 0, {tag, " R7 all low before common edge"},
            int'({qa[0], qb[0], qc[0], qfb}), 0);
        check_win(1, 0, {tag, " R7 common edge"});
        chk(qa[0] && qb[0] && qc[0] && qfb, {tag, " R7 all high on common edge"},
            int'({qa[0], qb[0], qc[0], qfb}), 15);
        check_win(300, 0, {tag, " R3 R4 R5 R6 ratios"});
    endtask

    task automatic t_bypass(input int which, input bit rs, input logic [1:0] fs, input string tag);
        start(which, 0, rs, 0, 1, 0, 1, fs, 1);
        check_win(250, 0, {tag, " R2 bypass source"});
    endtask

    task automatic t_gate();
        start(0, 1, 0, 0, 1, 0, 1, 2'b10, 1);
        check_win(27, 0, "R8 enabled");
        clk_en = 0;
        check_win(60, 1, "R9 disable transition");
        check_win(100, 2, "R8 banks held low, feedback running");
        clk_en = 1;
        check_win(60, 1, "R9 enable transition");
        check_win(100, 0, "R8 re-enabled");
    endtask

    task automatic t_retime();
        start(0, 1, 0, 0, 0, 0, 0, 2'b00, 1);
        check_win(30, 0, "R10 before select change");
        chg = s;
        sel_a = 1; n1[0] = 4;
        sel_c = 1; n1[2] = 6;
        check_win(200, 0, "R10 select change at alignment");
    endtask

    initial begin
        t_reset_async();
        t_ratios(0, 0, 1, 1, 2'b11, "P2 A2 B4 C6 F12");
        t_ratios(1, 1, 0, 0, 2'b01, "P4 A4 B2 C4 F6");
        t_bypass(1, 0, 2'b00, "ref0 F4");
        t_bypass(2, 1, 2'b10, "ref1 F8");
        t_gate();
        t_retime();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule